// File: doc/BRIEF.md
# Sprite Attribute Block Copy Engine

This block moves a fixed-size slab of bytes from general memory into sprite attribute memory on command. Software starts a copy by writing one byte to the trigger register at address 0xFF46. That byte is kept in a page register and can be read back. It also selects the source page: the copy reads from `{byte, 8'h00}` upward. The destination always begins at 0xFE00. Exactly 160 bytes move per copy, one per clock, in ascending order.

The engine drives a synchronous source read port. Data returns on the clock after the read is issued. The engine forwards that data straight to the destination write port one cycle after its read, so reading and writing overlap. While a copy runs, `busy` is high so that surrounding logic can hold off other users of the memories. A new trigger write during a copy abandons the old one and starts over from offset zero of the new page.

The controller is a four-state machine:
- IDLE waits for a trigger.
- FILL issues the first read with no write pending.
- STREAM reads the next byte while writing the previous one.
- DRAIN writes the last byte.

Its transitions are:
- IDLE→FILL on a trigger.
- FILL→STREAM on the next clock.
- STREAM→STREAM until the final read is issued, then STREAM→DRAIN.
- DRAIN→IDLE.
- Any state→FILL on a trigger (restart).

Top module: `sprite_dma`

## Requirements
- R1: A write with `cpu_wr_en` high and `cpu_addr` equal to 0xFF46 stores `cpu_wdata` into the page register. The stored value appears on `page_rdata` from the next cycle. Writes to any other address change neither `page_rdata` nor `busy`, and they start no reads or writes.
- R2: Source reads of a copy use addresses `{page, 8'h00} + k` for k = 0 up to 159, in ascending order. The first read (k = 0) is issued in the cycle right after the trigger write.
- R3: Each copy issues exactly 160 source reads and 160 destination writes.
- R4: Destination writes go to 0xFE00 + k for k = 0 up to 159, in ascending order, one address per write. The byte written to 0xFE00 + k is the byte read from source offset k.
- R5: After reset, `page_rdata` is 0xFF, `busy` is 0, and `src_rd_en` and `dst_wr_en` are 0.
- R6: Each destination write happens in the cycle after the source read that produced its data, and it carries the `src_rdata` returned for that read.
- R7: `busy` rises in the cycle after the trigger write. It stays high for 161 cycles, covering the last write, and falls in the following cycle.
- R8: A trigger write during a copy restarts the copy at offset 0 of the new page. In the cycle after the restart no write occurs. The next write goes to 0xFE00 with data from the new page, and the restarted copy again has 160 writes and 161 busy cycles.
- R9: While `busy` is low, `src_rd_en` and `dst_wr_en` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr_en | input | 1 | CPU register write strobe |
| cpu_addr | input | 16 | CPU write address |
| cpu_wdata | input | 8 | CPU write data |
| page_rdata | output | 8 | Current page register value |
| src_rd_en | output | 1 | Source read request |
| src_addr | output | 16 | Source read address |
| src_rdata | input | 8 | Source data, valid one cycle after the request |
| dst_wr_en | output | 1 | Sprite attribute memory write strobe |
| dst_addr | output | 16 | Sprite attribute memory write address |
| dst_wdata | output | 8 | Sprite attribute memory write data |
| busy | output | 1 | Copy in progress |

## Verification
The embedded properties check the following on every cycle:
- trigger capture and hold;
- the first source address following a trigger;
- that each write follows a read;
- that destination addresses stay in the window and step by one;
- that nothing moves while idle;
- that no stale write follows a restart.

Only the bench scenarios can show two further things. One is that all 160 bytes of several different pages arrive with the right contents. The other is that the read, write and busy counts come out exact for whole transfers and for a transfer cut short by a restart.

// File: rtl/sdma_pkg.sv
package sdma_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FILL   = 2'd1,
        ST_STREAM = 2'd2,
        ST_DRAIN  = 2'd3
    } sdma_state_e;
endpackage

// File: rtl/sdma_trigger_reg.sv
module sdma_trigger_reg #(
    parameter int          ADDR_W    = 16,
    parameter int          DATA_W    = 8,
    parameter logic [15:0] TRIG_ADDR = 16'hFF46,
    parameter logic [7:0]  RESET_VAL = 8'hFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              hit,
    output logic [DATA_W-1:0] page_q
);
    localparam logic [ADDR_W-1:0] MATCH = ADDR_W'(TRIG_ADDR);
    localparam logic [DATA_W-1:0] INIT  = DATA_W'(RESET_VAL);

    assign hit = wr_en && (addr == MATCH);

    always_ff @(posedge clk) begin
        if (!rst_n)   page_q <= INIT;
        else if (hit) page_q <= wdata;
    end

    AST_PAGE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> (page_q == $past(wdata)));                        // R1
    AST_PAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> $stable(page_q));                                // R1
endmodule

// File: rtl/sdma_counter.sv
module sdma_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] value
);
    always_ff @(posedge clk) begin
        if (!rst_n || clr) value <= '0;
        else if (inc)      value <= value + W'(1);
    end

    AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !clr) |-> (value != '1));                         // R3
endmodule

// File: rtl/sdma_fsm.sv
module sdma_fsm
    import sdma_pkg::*;
#(
    parameter int LEN   = 160,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] rd_idx,
    output logic             rd_go,
    output logic             wr_go,
    output logic             busy
);
    localparam logic [CNT_W-1:0] LAST_RD = CNT_W'(LEN - 1);

    sdma_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   state_d = start ? ST_FILL : ST_IDLE;
            ST_FILL:   state_d = start ? ST_FILL : ST_STREAM;
            ST_STREAM: begin
                if (start)                 state_d = ST_FILL;
                else if (rd_idx == LAST_RD) state_d = ST_DRAIN;
                else                       state_d = ST_STREAM;
            end
            ST_DRAIN:  state_d = start ? ST_FILL : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        rd_go = 1'b0;
        wr_go = 1'b0;
        busy  = 1'b1;
        unique case (state_q)
            ST_IDLE:   busy  = 1'b0;
            ST_FILL:   rd_go = 1'b1;
            ST_STREAM: begin
                rd_go = 1'b1;
                wr_go = 1'b1;
            end
            ST_DRAIN:  wr_go = 1'b1;
            default:   busy  = 1'b0;
        endcase
    end

    AST_RD_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        rd_go |-> (rd_idx < CNT_W'(LEN)));                        // R3
    AST_RESTART_NO_WR: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (busy && rd_go && !wr_go));                     // R8
    AST_BUSY_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> $rose(busy));                        // R7
endmodule

// File: rtl/sprite_dma.sv
module sprite_dma #(
    parameter int          ADDR_W    = 16,
    parameter int          DATA_W    = 8,
    parameter int          XFER_LEN  = 160,
    parameter logic [15:0] DST_BASE  = 16'hFE00,
    parameter logic [15:0] TRIG_ADDR = 16'hFF46,
    parameter logic [7:0]  RESET_VAL = 8'hFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_wr_en,
    input  logic [15:0]       cpu_addr,
    input  logic [7:0]        cpu_wdata,
    output logic [7:0]        page_rdata,
    output logic              src_rd_en,
    output logic [15:0]       src_addr,
    input  logic [7:0]        src_rdata,
    output logic              dst_wr_en,
    output logic [15:0]       dst_addr,
    output logic [7:0]        dst_wdata,
    output logic              busy
);
    localparam int              CNT_W      = $clog2(XFER_LEN + 1);
    localparam int              PAGE_SHIFT = ADDR_W - DATA_W;
    localparam logic [ADDR_W-1:0] DST_ORG  = ADDR_W'(DST_BASE);

    logic             start;
    logic [CNT_W-1:0] rd_idx, wr_idx;
    logic             rd_go, wr_go;

    sdma_trigger_reg #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .TRIG_ADDR(TRIG_ADDR), .RESET_VAL(RESET_VAL)
    ) u_trig (
        .clk(clk), .rst_n(rst_n), .wr_en(cpu_wr_en), .addr(cpu_addr),
        .wdata(cpu_wdata), .hit(start), .page_q(page_rdata)
    );

    sdma_counter #(.W(CNT_W)) u_rd_cnt (
        .clk(clk), .rst_n(rst_n), .clr(start), .inc(rd_go), .value(rd_idx)
    );

    sdma_counter #(.W(CNT_W)) u_wr_cnt (
        .clk(clk), .rst_n(rst_n), .clr(start), .inc(wr_go), .value(wr_idx)
    );

    sdma_fsm #(.LEN(XFER_LEN), .CNT_W(CNT_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .start(start), .rd_idx(rd_idx),
        .rd_go(rd_go), .wr_go(wr_go), .busy(busy)
    );

    assign src_rd_en = rd_go;
    assign src_addr  = (ADDR_W'(page_rdata) << PAGE_SHIFT) + ADDR_W'(rd_idx);
    assign dst_wr_en = wr_go;
    assign dst_addr  = DST_ORG + ADDR_W'(wr_idx);
    assign dst_wdata = src_rdata;

    AST_FIRST_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (src_rd_en &&
                   src_addr == (ADDR_W'($past(cpu_wdata)) << PAGE_SHIFT)));   // R2
    AST_DST_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        dst_wr_en |-> (dst_addr >= DST_ORG &&
                       dst_addr < DST_ORG + ADDR_W'(XFER_LEN)));              // R4
    AST_DST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (dst_wr_en && $past(dst_wr_en)) |-> (dst_addr == $past(dst_addr) + 16'd1)); // R4
    AST_WR_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n)
        dst_wr_en |-> $past(src_rd_en));                                      // R6
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!src_rd_en && !dst_wr_en));                                // R9
endmodule

// File: tb/tb_sprite_dma.sv
module tb_sprite_dma;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_wr_en = 1'b0;
    logic [15:0] cpu_addr = 16'h0000;
    logic [7:0]  cpu_wdata = 8'h00;
    logic [7:0]  page_rdata;
    logic        src_rd_en;
    logic [15:0] src_addr;
    logic [7:0]  src_rdata = 8'h00;
    logic        dst_wr_en;
    logic [15:0] dst_addr;
    logic [7:0]  dst_wdata;
    logic        busy;

    always #10 clk = ~clk;  // 50 MHz

    sprite_dma dut (
        .clk(clk), .rst_n(rst_n), .cpu_wr_en(cpu_wr_en), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .page_rdata(page_rdata), .src_rd_en(src_rd_en),
        .src_addr(src_addr), .src_rdata(src_rdata), .dst_wr_en(dst_wr_en),
        .dst_addr(dst_addr), .dst_wdata(dst_wdata), .busy(busy)
    );

    int checks = 0;
    int errors = 0;

    // page (8 bits) and expected busy length (9 bits)
    localparam int NVEC = 6;
    localparam logic [16:0] VECS [NVEC] = '{
        {8'h00, 9'd161}, {8'hC0, 9'd161}, {8'h81, 9'd161},
        {8'hFF, 9'd161}, {8'h12, 9'd161}, {8'hD3, 9'd161}
    };

    function automatic logic [7:0] src_byte(input logic [15:0] a);
        logic [7:0] t;
        t = a[7:0] * 8'd7;
        return a[15:8] ^ t ^ 8'hA5;
    endfunction

    logic [7:0]  dst_mem [160];
    int          rd_cnt, wr_cnt, rd_bad, pipe_bad, oob;
    logic [15:0] exp_base;
    logic [15:0] first_wr;
    logic        prev_rd = 1'b0;
    logic [15:0] prev_addr = 16'h0;

    always @(posedge clk) begin
        src_rdata <= src_rd_en ? src_byte(src_addr) : 8'h00;
        if (rst_n && src_rd_en) begin
            if (src_addr != exp_base + 16'(rd_cnt)) rd_bad++;
            rd_cnt++;
        end
        if (rst_n && dst_wr_en) begin
            if (dst_addr < 16'hFE00 || dst_addr >= 16'hFEA0) oob++;
            else dst_mem[dst_addr - 16'hFE00] = dst_wdata;
            if (!prev_rd || dst_wdata != src_byte(prev_addr)) pipe_bad++;
            if (wr_cnt == 0) first_wr = dst_addr;
            wr_cnt++;
        end
        prev_rd   = src_rd_en;
        prev_addr = src_addr;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_counts(input logic [7:0] pg);
        rd_cnt = 0; wr_cnt = 0; rd_bad = 0; pipe_bad = 0; oob = 0;
        first_wr = 16'hFFFF;
        exp_base = {pg, 8'h00};
    endtask

    // drives a write at a negedge; returns at the negedge after the capturing edge
    task automatic cpu_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_wr_en = 1'b1; cpu_addr = a; cpu_wdata = d;
        @(negedge clk);
        cpu_wr_en = 1'b0;
    endtask

    task automatic count_busy(output int n);
        n = 0;
        while (busy && n < 400) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic check_contents(input logic [7:0] pg, input string req);
        int bad = 0;
        int first_bad = -1;
        for (int k = 0; k < 160; k++) begin
            if (dst_mem[k] !== src_byte({pg, 8'(k)})) begin
                bad++;
                if (first_bad < 0) first_bad = k;
            end
        end
        check(bad == 0, req, bad, 0);
        if (first_bad >= 0)
            check(1'b0, req, int'(dst_mem[first_bad]), int'(src_byte({pg, 8'(first_bad)})));
    endtask

    task automatic run_copy(input logic [7:0] pg, input int exp_len);
        int blen;
        for (int k = 0; k < 160; k++) dst_mem[k] = 8'h00;
        cpu_write(16'hFF46, pg);
        clear_counts(pg);
        check(page_rdata == pg, "R1 readback", page_rdata, pg);
        check(busy == 1'b1, "R7 busy rise", busy, 1);
        check(src_rd_en && src_addr == {pg, 8'h00}, "R2 first addr", src_addr, {pg, 8'h00});
        count_busy(blen);
        check(blen == exp_len, "R7 busy length", blen, exp_len);
        check(rd_cnt == 160, "R3 read count", rd_cnt, 160);
        check(wr_cnt == 160, "R3 write count", wr_cnt, 160);
        check(rd_bad == 0, "R2 read order", rd_bad, 0);
        check(oob == 0 && first_wr == 16'hFE00, "R4 dest start", first_wr, 16'hFE00);
        check(pipe_bad == 0, "R6 pipeline", pipe_bad, 0);
        check_contents(pg, "R4 contents");
        repeat (5) @(negedge clk);
        check(rd_cnt == 160 && wr_cnt == 160 && !src_rd_en && !dst_wr_en,
              "R9 idle quiet", wr_cnt, 160);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int blen;
        clear_counts(8'h00);
        repeat (3) @(negedge clk);
        // R5: reset state
        check(page_rdata == 8'hFF, "R5 page reset", page_rdata, 8'hFF);
        check(!busy && !src_rd_en && !dst_wr_en, "R5 idle reset", busy, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(page_rdata == 8'hFF && !busy, "R5 after release", page_rdata, 8'hFF);

        // table-driven transfers
        for (int v = 0; v < NVEC; v++)
            run_copy(VECS[v][16:9], int'(VECS[v][8:0]));

        // R1: writes to neighbouring addresses are ignored
        clear_counts(8'h00);
        cpu_write(16'hFF45, 8'h33);
        check(page_rdata == VECS[NVEC-1][16:9], "R1 ignore FF45", page_rdata, VECS[NVEC-1][16:9]);
        cpu_write(16'hFF47, 8'h44);
        repeat (3) @(negedge clk);
        check(page_rdata == VECS[NVEC-1][16:9], "R1 ignore FF47", page_rdata, VECS[NVEC-1][16:9]);
        check(!busy && rd_cnt == 0 && wr_cnt == 0, "R1 no start", rd_cnt, 0);

        // R8: restart mid-copy
        for (int k = 0; k < 160; k++) dst_mem[k] = 8'h00;
        cpu_write(16'hFF46, 8'h40);
        repeat (50) @(negedge clk);
        cpu_write(16'hFF46, 8'h9C);
        clear_counts(8'h9C);
        check(busy && src_rd_en && !dst_wr_en && src_addr == 16'h9C00,
              "R8 restart fill", src_addr, 16'h9C00);
        count_busy(blen);
        check(blen == 161, "R8 restart busy", blen, 161);
        check(wr_cnt == 160 && rd_cnt == 160, "R8 restart counts", wr_cnt, 160);
        check(first_wr == 16'hFE00, "R8 restart first dest", first_wr, 16'hFE00);
        check(pipe_bad == 0 && rd_bad == 0, "R8 restart order", pipe_bad + rd_bad, 0);
        check_contents(8'h9C, "R8 restart contents");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule